// File: doc/BRIEF.md
# Free-Running Interval Timer

This block is a 16-bit down-counting interval timer behind a byte-wide register bus. Software first writes a 16-bit reload value, low byte then high byte. The high-byte write copies the whole value into the counter and starts it. Each timeout raises an interrupt flag. When that flag is enabled, it pulls an active-low interrupt line.

In continuous mode the counter reloads itself from the stored value after every timeout. The interval from one timeout to the next is the stored value plus two clocks, so a 50 Hz tick from a 1.8432 MHz clock takes a reload value of 36862. In one-shot mode only the first timeout after a start raises the flag, and the counter keeps counting down through 0xFFFF without reloading. A separate control bit can make an output pin change level on each timeout.

Register offsets (4-bit address): 4 counter low, 5 counter high, 6 reload low, 7 reload high, 0xB mode, 0xD flags, 0xE enables.

Top module: `tick_timer`

## Requirements
- R1: After reset, irqN is 1 and sqOut is 0. Reading offset 0xD returns 0x00, 0xB returns 0x00 and 0xE returns 0x80. The counter does not move and reads 0x0000 at offsets 4/5.
- R2: A write to offset 5 loads the counter with {written byte, reload low byte}, starts the count and clears the flag. A read of offsets 4/5 at N cycles after that write's clock edge returns (value − N) mod 65536, as long as no reload has taken place.
- R3: When mode bit 6 = 1 (continuous), the first timeout raises the flag N+1 cycles after the start edge, where N is the loaded value. Every later timeout comes N+2 cycles after the one before it.
- R4: When mode bit 6 = 0 (one-shot), only the first timeout after a start raises the flag. The counter then keeps counting down through 0xFFFF and does not reload.
- R5: Writing offset 0xE with bit 7 = 1 sets each enable bit that is written as 1. With bit 7 = 0, each enable bit written as 1 is cleared. Bits written as 0 keep their value. A read returns bit 7 as 1 and the timer enable in bit 6.
- R6: A read of offset 0xD returns the timer flag in bit 6 and, in bit 7, the AND of the flag with its enable. irqN is 0 exactly when that bit 7 is 1.
- R7: Writing offset 0xD with bit 6 = 1 clears the flag, and writing 0 to bit 6 leaves it unchanged. When a clear and a timeout fall on the same edge, the flag ends up set.
- R8: A read of offset 4 clears the flag. A read of offset 5 does not.
- R9: Writes to offsets 6 and 7 change the stored reload value and do not touch the counter or the flag. The next reload uses the new value.
- R10: When mode bit 7 = 1, sqOut changes level on every flag-raising timeout. When mode bit 7 = 0, sqOut holds its level.
- R11: Offset 0xB reads back bits 7 and 6 as they were last written, with the other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| rdEn | input | 1 | Read strobe; read side effects take place on the edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| irqN | output | 1 | Active-low interrupt request |
| sqOut | output | 1 | Output that changes level on each timeout |

## Verification
The assertions assume that wrEn and rdEn are never high in the same cycle, that the bus is quiet while reset is low, and that a write to offset 5 does not fall on the edge where a timeout is due. The stimulus drives one single-cycle access at a time on the falling edge and leaves every strobe low in between. It places the one deliberate clear/timeout overlap by counting cycles from a measured flag edge, and never lets a start coincide with a timeout.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_RLD_LO = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_RLD_HI = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_ENA    = 4'hE;

  typedef struct packed {
    logic wrRldLo;
    logic wrRldHi;
    logic start;
    logic readLo;
  } tmrStrobes_t;
endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              freeRun,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reload,
  output logic              timeoutEv
);
  localparam int HI_W = CNT_W - DATA_W;

  logic running;
  logic reloadPend;
  logic armed;

  assign timeoutEv = running && !strb.start && !reloadPend &&
                     (count == '0) && (freeRun || armed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reload     <= '0;
      count      <= '0;
      running    <= 1'b0;
      reloadPend <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (strb.wrRldLo) reload[DATA_W-1:0] <= wrData;
      if (strb.wrRldHi) reload[CNT_W-1:DATA_W] <= wrData[HI_W-1:0];
      if (strb.start) begin
        count      <= {wrData[HI_W-1:0], reload[DATA_W-1:0]};
        running    <= 1'b1;
        armed      <= 1'b1;
        reloadPend <= 1'b0;
      end else if (running) begin
        if (reloadPend) begin
          count      <= reload;
          reloadPend <= 1'b0;
        end else begin
          count <= count - 1'b1;
          if (count == '0) begin
            reloadPend <= freeRun;
            armed      <= armed && freeRun;
          end
        end
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> count == {$past(wrData[HI_W-1:0]), $past(reload[DATA_W-1:0])}); // R2

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (running && reloadPend && !strb.start) |=> count == $past(reload)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (running && !reloadPend && !strb.start) |=> count == CNT_W'($past(count) - 1'b1)); // R4
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  reload,
  input  logic              timeoutEv,
  output tmrStrobes_t       strb,
  output logic              freeRun,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN,
  output logic              sqOut
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam int SEL_BIT = DATA_W - 1;
  localparam int TMR_BIT = DATA_W - 2;

  logic sqEnable;
  logic tmrFlag;
  logic tmrEnable;
  logic anyIrq;
  logic flagClr;
  logic wrMode;
  logic wrFlag;
  logic wrEna;

  always_comb begin
    strb.wrRldLo = wrEn && (addr == OFS_CNT_LO || addr == OFS_RLD_LO);
    strb.wrRldHi = wrEn && (addr == OFS_CNT_HI || addr == OFS_RLD_HI);
    strb.start   = wrEn && (addr == OFS_CNT_HI);
    strb.readLo  = rdEn && (addr == OFS_CNT_LO);
  end

  assign wrMode  = wrEn && (addr == OFS_MODE);
  assign wrFlag  = wrEn && (addr == OFS_FLAG);
  assign wrEna   = wrEn && (addr == OFS_ENA);
  assign flagClr = strb.start || strb.readLo || (wrFlag && wrData[TMR_BIT]);
  assign anyIrq  = tmrFlag && tmrEnable;
  assign irqN    = !anyIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqEnable  <= 1'b0;
      freeRun   <= 1'b0;
      tmrFlag   <= 1'b0;
      tmrEnable <= 1'b0;
      sqOut     <= 1'b0;
    end else begin
      if (wrMode) begin
        sqEnable <= wrData[SEL_BIT];
        freeRun  <= wrData[TMR_BIT];
      end
      if (timeoutEv)    tmrFlag <= 1'b1;
      else if (flagClr) tmrFlag <= 1'b0;
      if (wrEna && wrData[TMR_BIT]) tmrEnable <= wrData[SEL_BIT];
      if (timeoutEv && sqEnable) sqOut <= !sqOut;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      OFS_CNT_LO: rdData = count[DATA_W-1:0];
      OFS_CNT_HI: rdData[HI_W-1:0] = count[CNT_W-1:DATA_W];
      OFS_RLD_LO: rdData = reload[DATA_W-1:0];
      OFS_RLD_HI: rdData[HI_W-1:0] = reload[CNT_W-1:DATA_W];
      OFS_MODE: begin
        rdData[SEL_BIT] = sqEnable;
        rdData[TMR_BIT] = freeRun;
      end
      OFS_FLAG: begin
        rdData[SEL_BIT] = anyIrq;
        rdData[TMR_BIT] = tmrFlag;
      end
      OFS_ENA: begin
        rdData[SEL_BIT] = 1'b1;
        rdData[TMR_BIT] = tmrEnable;
      end
      default: rdData = '0;
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEv |=> tmrFlag); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readLo && !timeoutEv) |=> !tmrFlag); // R8

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEna && wrData[SEL_BIT] && wrData[TMR_BIT]) |=> tmrEnable); // R5

  AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEna && !wrData[SEL_BIT] && wrData[TMR_BIT]) |=> !tmrEnable); // R5

  AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sqEnable && !timeoutEv) |=> $stable(sqOut)); // R10
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN,
  output logic              sqOut
);
  tmrStrobes_t      strb;
  logic             freeRun;
  logic             timeoutEv;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;

  tick_timer_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .count(count), .reload(reload), .timeoutEv(timeoutEv),
    .strb(strb), .freeRun(freeRun), .rdData(rdData), .irqN(irqN), .sqOut(sqOut)
  );

  tick_timer_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .freeRun(freeRun),
    .count(count), .reload(reload), .timeoutEv(timeoutEv)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  localparam int VEC_LOAD [NVEC] = '{3, 6, 17, 300};
  localparam int VEC_FIRST[NVEC] = '{4, 7, 18, 301};
  localparam int VEC_PER  [NVEC] = '{5, 8, 19, 302};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqN;
  logic       sqOut;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irqN(irqN), .sqOut(sqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output int at);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData; at = cyc;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitFall(output int t);
    do @(negedge clk); while (irqN !== 1'b0);
    t = cyc;
  endtask

  task automatic startTimer(input int n, output int s);
    wr(4'h4, n[7:0]);
    wr(4'h5, n[15:8]);
    s = cyc;
  endtask

  initial begin
    logic [7:0] d;
    int at, s, t1, t2, t3, exp;

    doReset();
    rd(4'hD, d, at); check(d == 8'h00, "R1 flag reg", d, 8'h00);
    rd(4'hB, d, at); check(d == 8'h00, "R1 mode reg", d, 8'h00);
    rd(4'hE, d, at); check(d == 8'h80, "R1 enable reg", d, 8'h80);
    repeat (5) @(negedge clk);
    rd(4'h4, d, at); check(d == 8'h00, "R1 counter stopped lo", d, 0);
    rd(4'h5, d, at); check(d == 8'h00, "R1 counter stopped hi", d, 0);
    check(irqN === 1'b1 && sqOut === 1'b0, "R1 pins", {irqN, sqOut}, 2'b10);

    // R3 continuous mode: table of load values, first timeout and period
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      wr(4'hB, 8'h40);
      wr(4'hE, 8'hC0);
      startTimer(VEC_LOAD[i], s);
      waitFall(t1);
      check(t1 - s == VEC_FIRST[i], "R3 first timeout", t1 - s, VEC_FIRST[i]);
      wr(4'hD, 8'h40);
      waitFall(t2);
      check(t2 - t1 == VEC_PER[i], "R3 period", t2 - t1, VEC_PER[i]);
    end

    // R11 mode readback
    doReset();
    wr(4'hB, 8'hFF);
    rd(4'hB, d, at); check(d == 8'hC0, "R11 mode readback", d, 8'hC0);

    // R2 count-down after start
    doReset();
    wr(4'hB, 8'h40);
    startTimer(16'h1234, s);
    repeat (3) @(negedge clk);
    rd(4'h5, d, at); exp = (16'h1234 - (at - s)) >> 8;
    check(d == exp[7:0], "R2 counter hi", d, exp);
    rd(4'h4, d, at); exp = (16'h1234 - (at - s)) & 8'hFF;
    check(d == exp[7:0], "R2 counter lo", d, exp);

    // R4 one-shot
    doReset();
    wr(4'hE, 8'hC0);
    startTimer(4, s);
    waitFall(t1);
    check(t1 - s == 5, "R4 one-shot first timeout", t1 - s, 5);
    wr(4'hD, 8'h40);
    repeat (20) @(negedge clk);
    check(irqN === 1'b1, "R4 no second flag", irqN, 1);
    rd(4'h5, d, at); exp = ((4 - (at - s)) & 16'hFFFF) >> 8;
    check(d == exp[7:0], "R4 wraps hi", d, exp);
    rd(4'h4, d, at); exp = (4 - (at - s)) & 8'hFF;
    check(d == exp[7:0], "R4 no reload lo", d, exp);

    // R5 / R6 enable set/clear and flag reg
    doReset();
    wr(4'hB, 8'h40);
    startTimer(6, s);
    do @(negedge clk); while (cyc - s < 9);
    rd(4'hD, d, at); check(d == 8'h40, "R6 flag set, disabled", d, 8'h40);
    check(irqN === 1'b1, "R6 irq idle when disabled", irqN, 1);
    wr(4'hE, 8'hC0);
    rd(4'hE, d, at); check(d == 8'hC0, "R5 enable set", d, 8'hC0);
    check(irqN === 1'b0, "R6 irq active", irqN, 0);
    rd(4'hD, d, at); check(d == 8'hC0, "R6 flag reg summary", d, 8'hC0);
    wr(4'hE, 8'h00);
    rd(4'hE, d, at); check(d == 8'hC0, "R5 zero bits unchanged", d, 8'hC0);
    wr(4'hE, 8'h40);
    rd(4'hE, d, at); check(d == 8'h80, "R5 enable cleared", d, 8'h80);
    check(irqN === 1'b1, "R6 irq off when cleared", irqN, 1);

    // R7 write-one clear, write-zero no effect, set wins
    doReset();
    wr(4'hB, 8'h40);
    wr(4'hE, 8'hC0);
    startTimer(5, s);
    waitFall(t1);
    wr(4'hD, 8'h00);
    check(irqN === 1'b0, "R7 write zero keeps flag", irqN, 0);
    wr(4'hD, 8'h40);
    check(irqN === 1'b1, "R7 write one clears", irqN, 1);
    waitFall(t1);
    wr(4'hD, 8'h40);
    do @(negedge clk); while (cyc < t1 + 5);
    wr(4'hD, 8'h40);
    check(irqN === 1'b0, "R7 set wins over clear", irqN, 0);

    // R8 read side effects
    rd(4'h5, d, at);
    check(irqN === 1'b0, "R8 hi read keeps flag", irqN, 0);
    rd(4'h4, d, at);
    check(irqN === 1'b1, "R8 lo read clears", irqN, 1);

    // R9 reload rewrite without restart
    doReset();
    wr(4'hB, 8'h40);
    wr(4'hE, 8'hC0);
    startTimer(10, s);
    wr(4'h7, 8'h00);
    wr(4'h6, 8'd20);
    check(irqN === 1'b1, "R9 latch write leaves flag", irqN, 1);
    rd(4'h4, d, at); exp = 10 - (at - s);
    check(d == exp[7:0], "R9 counter untouched", d, exp);
    waitFall(t1);
    wr(4'hD, 8'h40);
    waitFall(t2);
    wr(4'hD, 8'h40);
    waitFall(t3);
    check(t2 - t1 == 22 && t3 - t2 == 22, "R9 new period", t3 - t2, 22);

    // R10 square output
    doReset();
    wr(4'hB, 8'hC0);
    wr(4'hE, 8'hC0);
    startTimer(3, s);
    check(sqOut === 1'b0, "R10 initial level", sqOut, 0);
    waitFall(t1);
    check(sqOut === 1'b1, "R10 first toggle", sqOut, 1);
    wr(4'hD, 8'h40);
    waitFall(t2);
    check(sqOut === 1'b0, "R10 second toggle", sqOut, 0);
    wr(4'hB, 8'h40);
    wr(4'hD, 8'h40);
    waitFall(t3);
    check(sqOut === 1'b0, "R10 hold when off", sqOut, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule